// File: doc/BRIEF.md
# Three-Stage Cascaded Delta-Sigma Divider Modulator

This block turns a programmable integer word and a fixed-width fraction word into a stream of small signed integers whose long-term average equals integer + fraction / 2^FRAC_W. It drives the modulus control of a fractional-N divider. Three first-order accumulators are chained. The first adds the fraction, with an optional signed dither term, to its state. Each later stage adds the state of the stage before it. Each stage emits a one-bit overflow. These overflows are recombined with a noise-cancelling difference network, so the quantisation noise is pushed to high frequencies and the output spreads over several values around the integer instead of toggling between two neighbours.

The stages are separated by registers, so no carry chain is longer than one accumulator. The overflows from earlier stages are held in short delay lines until the later stages catch up, which keeps the result bit-identical to an unpipelined cascade. A synchronous initialise input loads a programmable seed into each accumulator and restarts the pipeline. A clock-enable input freezes all state.

Top module: `mash3_modulator`

## Requirements
- R1: With integer I (6-bit unsigned) and fraction F (20-bit unsigned), the mean of 65536 consecutive valid outputs lies within 4/65536 of I + F/2^20.
- R2: Each valid output equals the unpipelined reference. For sample n with increment x: s1 = a1 + x, s2 = a2 + (s1 mod 2^20), s3 = a3 + (s2 mod 2^20), and ck = sk ≥ 2^20, with each ak taking sk mod 2^20. The output is I + c1 + c2[n] − c2[n−1] + c3[n] − 2·c3[n−1] + c3[n−2], where the carry history is zero before sample 0.
- R3: Every valid output is an 8-bit two's complement value in the range I − 3 to I + 4.
- R4: With zero increment and zero seeds, every valid output equals I exactly.
- R5: After an initialise cycle, valid is low. It rises after the fourth enabled clock edge, and that output is sample 0, which is formed from the inputs at the first enabled edge after the initialise edge.
- R6: The initialise cycle loads the three seed inputs into accumulators 1, 2 and 3 and clears the carry history. With seed 1 = 2^20 − 1, seeds 2 and 3 = 0 and F = 1, sample 0 is I + 1.
- R7: While enable is low, no state changes and the output and valid flag hold their values. Once enable returns high, the sequence continues as if the stall had not happened.
- R8: The stage-1 increment is F plus the sign-extended 8-bit dither, clamped to the range 0 through 2^20 − 1.
- R9: A change of the integer input reaches the output with the same four-edge latency as the fraction.
- R10: While reset is high and after it, the output is 0 and valid is low until an enabled fill completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock enable for all state |
| init | input | 1 | Load seeds and restart the fill (takes priority over en) |
| int_i | input | 6 | Integer part of the divide value |
| frac_i | input | 20 | Fraction numerator over 2^20 |
| dith_i | input | 8 | Signed dither added to the fraction |
| seed1_i | input | 20 | Initial value of accumulator 1 |
| seed2_i | input | 20 | Initial value of accumulator 2 |
| seed3_i | input | 20 | Initial value of accumulator 3 |
| out_o | output | 8 | Signed modulus control value |
| valid_o | output | 1 | Output holds a real sample |

## Verification
Inputs present at an enabled edge show up at the output after the third enabled edge that follows, which is four enabled edges counting the capture edge. Stalled edges do not count. The bench records each sample from its own reference model at the edge that captures the inputs and queues it. It removes a sample from the queue only after an enabled edge that leaves valid high, and it reads the output at the falling edge. The latency, integer-change and seed checks count the edges directly from the initialise or change point, and the stall check compares against the value held just before enable went low.

// File: rtl/mash_pkg.sv
package mash_pkg;
  // number of cascaded first-order stages (1-1-1 structure)
  localparam int MASH_STAGES = 3;
  // enabled edges from input capture to a valid output
  localparam int MASH_LAT = MASH_STAGES + 1;
  // signed width of the recombined carry term (-3..+4)
  localparam int NC_W = 4;
endpackage

// File: rtl/mash_delay.sv
module mash_delay #(
  parameter int W     = 1,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) pipe_q[i] <= '0;
    end else if (en) begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[DEPTH-1];
endmodule

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init,
  input  logic         step_i,
  input  logic [W-1:0] seed_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] acc_o,
  output logic         carry_o
);
  logic [W-1:0] acc_q;
  logic         carry_q;
  logic [W:0]   sum;

  always_comb sum = {1'b0, acc_q} + {1'b0, din_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (init) begin
      acc_q   <= seed_i;
      carry_q <= 1'b0;
    end else if (step_i) begin
      acc_q   <= sum[W-1:0];
      carry_q <= sum[W];
    end
  end

  assign acc_o   = acc_q;
  assign carry_o = carry_q;

  // seed is taken on initialise, carry cleared
  assert_seed_load_R6: assert property (@(posedge clk) disable iff (rst)
    init |=> (acc_q == $past(seed_i)) && !carry_q);

  // an idle stage keeps its state
  assert_stage_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !init) |=> $stable(acc_q) && $stable(carry_q));
endmodule

// File: rtl/mash_noise_cancel.sv
module mash_noise_cancel
  import mash_pkg::*;
#(
  parameter int INT_W = 6,
  parameter int OUT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    init,
  input  logic                    step_i,
  input  logic [MASH_STAGES-1:0]  cy_i,
  input  logic [INT_W-1:0]        int_i,
  output logic signed [OUT_W-1:0] out_o
);
  logic                    c2_p, c3_p, c3_pp;
  logic signed [NC_W-1:0]  nc;
  logic signed [OUT_W-1:0] y_next;
  logic signed [OUT_W-1:0] out_q;

  // c1 + (1-z^-1)c2 + (1-z^-1)^2 c3
  always_comb begin
    nc = $signed({3'b000, cy_i[0]})
       + $signed({3'b000, cy_i[1]}) - $signed({3'b000, c2_p})
       + $signed({3'b000, cy_i[2]}) - $signed({2'b00, c3_p, 1'b0})
       + $signed({3'b000, c3_pp});
    y_next = $signed({{(OUT_W-INT_W){1'b0}}, int_i})
           + $signed({{(OUT_W-NC_W){nc[NC_W-1]}}, nc});
  end

  always_ff @(posedge clk) begin
    if (rst || init) begin
      c2_p  <= 1'b0;
      c3_p  <= 1'b0;
      c3_pp <= 1'b0;
      out_q <= '0;
    end else if (step_i) begin
      c2_p  <= cy_i[1];
      c3_p  <= cy_i[2];
      c3_pp <= c3_p;
      out_q <= y_next;
    end
  end

  assign out_o = out_q;

  assert_out_range_R3: assert property (@(posedge clk) disable iff (rst)
    (step_i && !init) |=> ((int'(out_o) - int'($past(int_i))) >= -3) &&
                          ((int'(out_o) - int'($past(int_i))) <= 4));

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !init) |=> $stable(out_o));
endmodule

// File: rtl/mash3_modulator.sv
module mash3_modulator
  import mash_pkg::*;
#(
  parameter int FRAC_W = 20,
  parameter int INT_W  = 6,
  parameter int DITH_W = 8,
  localparam int OUT_W = INT_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     init,
  input  logic [INT_W-1:0]         int_i,
  input  logic [FRAC_W-1:0]        frac_i,
  input  logic signed [DITH_W-1:0] dith_i,
  input  logic [FRAC_W-1:0]        seed1_i,
  input  logic [FRAC_W-1:0]        seed2_i,
  input  logic [FRAC_W-1:0]        seed3_i,
  output logic signed [OUT_W-1:0]  out_o,
  output logic                     valid_o
);
  localparam int XW = FRAC_W + 2;
  localparam logic [FRAC_W-1:0] FRAC_MAX = '1;

  logic signed [XW-1:0]   x_wide;
  logic [FRAC_W-1:0]      x_eff;
  logic [MASH_LAT-1:0]    vld_q;
  logic [INT_W-1:0]       int_q, int_al;
  logic [FRAC_W-1:0]      seed_arr [MASH_STAGES];
  logic [FRAC_W-1:0]      stg_in   [MASH_STAGES];
  logic [FRAC_W-1:0]      stg_acc  [MASH_STAGES];
  logic [MASH_STAGES-1:0] stg_cy, stg_step, cy_al;

  // fraction plus dither, clamped into the accumulator range
  always_comb begin
    x_wide = $signed({2'b00, frac_i})
           + $signed({{(XW-DITH_W){dith_i[DITH_W-1]}}, dith_i});
    if (x_wide < 0)                        x_eff = '0;
    else if (x_wide[XW-1:FRAC_W] != '0)    x_eff = FRAC_MAX;
    else                                   x_eff = x_wide[FRAC_W-1:0];
  end

  // fill tracker: bit k set once stage k+1 has seen its first sample
  always_ff @(posedge clk) begin
    if (rst || init)  vld_q <= '0;
    else if (en)      vld_q <= {vld_q[MASH_LAT-2:0], 1'b1};
  end
  assign valid_o = vld_q[MASH_LAT-1];

  always_ff @(posedge clk) begin
    if (rst)         int_q <= '0;
    else if (en)     int_q <= int_i;
  end

  assign seed_arr[0] = seed1_i;
  assign seed_arr[1] = seed2_i;
  assign seed_arr[2] = seed3_i;

  for (genvar k = 0; k < MASH_STAGES; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign stg_in[k]   = x_eff;
      assign stg_step[k] = en;
    end else begin : g_tail
      assign stg_in[k]   = stg_acc[k-1];
      assign stg_step[k] = en & vld_q[k-1];
    end

    mash_acc_stage #(.W(FRAC_W)) u_acc (
      .clk     (clk),
      .rst     (rst),
      .init    (init),
      .step_i  (stg_step[k]),
      .seed_i  (seed_arr[k]),
      .din_i   (stg_in[k]),
      .acc_o   (stg_acc[k]),
      .carry_o (stg_cy[k])
    );

    if (k < MASH_STAGES - 1) begin : g_align
      mash_delay #(.W(1), .DEPTH(MASH_STAGES - 1 - k)) u_cdly (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .d_i (stg_cy[k]),
        .q_o (cy_al[k])
      );
    end else begin : g_last
      assign cy_al[k] = stg_cy[k];
    end
  end

  mash_delay #(.W(INT_W), .DEPTH(MASH_STAGES - 1)) u_idly (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .d_i (int_q),
    .q_o (int_al)
  );

  mash_noise_cancel #(.INT_W(INT_W), .OUT_W(OUT_W)) u_nc (
    .clk    (clk),
    .rst    (rst),
    .init   (init),
    .step_i (en & vld_q[MASH_LAT-2]),
    .cy_i   (cy_al),
    .int_i  (int_al),
    .out_o  (out_o)
  );

  assert_valid_cleared_R5: assert property (@(posedge clk) disable iff (rst)
    init |=> !valid_o);

  assert_valid_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!en && !init) |=> $stable(valid_o));

  // last stage integrates the state handed on by the middle stage
  assert_stage3_accumulates_R2: assert property (@(posedge clk) disable iff (rst)
    (stg_step[2] && !init) |=>
      (stg_acc[2] == FRAC_W'($past(stg_acc[2]) + $past(stg_acc[1]))));
endmodule

// File: tb/mash3_modulator_tb.sv
module mash3_modulator_tb;
  localparam int FRAC_W = 20;
  localparam int INT_W  = 6;
  localparam int DITH_W = 8;
  localparam int OUT_W  = 8;
  localparam longint M  = longint'(1) << FRAC_W;

  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b0, init = 1'b0;
  logic [INT_W-1:0] int_i = '0;
  logic [FRAC_W-1:0] frac_i = '0, seed1_i = '0, seed2_i = '0, seed3_i = '0;
  logic signed [DITH_W-1:0] dith_i = '0;
  logic signed [OUT_W-1:0] out_o;
  logic valid_o;

  mash3_modulator #(.FRAC_W(FRAC_W), .INT_W(INT_W), .DITH_W(DITH_W)) u_dut (
    .clk(clk), .rst(rst), .en(en), .init(init), .int_i(int_i), .frac_i(frac_i),
    .dith_i(dith_i), .seed1_i(seed1_i), .seed2_i(seed2_i), .seed3_i(seed3_i),
    .out_o(out_o), .valid_o(valid_o));

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  longint a1, a2, a3;
  int c2p, c3p, c3pp;
  int exp_q[$];
  int int_qq[$];
  bit sum_on = 0;
  longint sum_acc;
  int n_sum;
  int cyc_cnt = 0;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint clampx(longint f, longint d);
    longint x = f + d;
    if (x < 0) return 0;
    if (x > M - 1) return M - 1;
    return x;
  endfunction

  task automatic model_seed(longint s1, longint s2, longint s3);
    a1 = s1; a2 = s2; a3 = s3;
    c2p = 0; c3p = 0; c3pp = 0;
    exp_q.delete(); int_qq.delete();
  endtask

  task automatic model_step(longint x, int iv);
    longint s1, s2, s3;
    int c1, c2, c3, y;
    s1 = a1 + x;  c1 = (s1 >= M) ? 1 : 0; a1 = s1 % M;
    s2 = a2 + a1; c2 = (s2 >= M) ? 1 : 0; a2 = s2 % M;
    s3 = a3 + a2; c3 = (s3 >= M) ? 1 : 0; a3 = s3 % M;
    y = iv + c1 + c2 - c2p + c3 - 2 * c3p + c3pp;
    c3pp = c3p; c3p = c3; c2p = c2;
    exp_q.push_back(y);
    int_qq.push_back(iv);
  endtask

  // one clock: update the model at the edge, compare at the falling edge
  task automatic cyc();
    bit e, i, r;
    int ev, iv;
    @(posedge clk);
    e = en; i = init; r = rst;
    if (r) model_seed(0, 0, 0);
    else if (i) model_seed(seed1_i, seed2_i, seed3_i);
    else if (e) model_step(clampx(frac_i, dith_i), int_i);
    @(negedge clk);
    if (!r && !i && e && valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 (no queued sample)", int'(out_o), -999);
      end else begin
        ev = exp_q.pop_front();
        iv = int_qq.pop_front();
        check(int'(out_o) == ev, "R2", int'(out_o), ev);
        check(int'(out_o) >= iv - 3 && int'(out_o) <= iv + 4, "R3", int'(out_o), iv);
        if (sum_on) begin
          sum_acc += out_o;
          n_sum++;
        end
      end
    end
  endtask

  task automatic do_init(longint s1, longint s2, longint s3);
    seed1_i = FRAC_W'(s1); seed2_i = FRAC_W'(s2); seed3_i = FRAC_W'(s3);
    init = 1'b1;
    cyc();
    init = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b1;
    cyc(); cyc();
    check(out_o == 0, "R10 out in reset", int'(out_o), 0);
    check(valid_o == 0, "R10 valid in reset", int'(valid_o), 0);
    rst = 1'b0;
    cyc();
    check(valid_o == 0, "R10 valid after reset", int'(valid_o), 0);
  endtask

  task automatic t_latency();
    int_i = 12; frac_i = 0; dith_i = 0; en = 1'b1;
    do_init(0, 0, 0);
    for (int k = 1; k <= 4; k++) begin
      cyc();
      check(valid_o == (k == 4), "R5 valid timing", int'(valid_o), int'(k == 4));
    end
  endtask

  task automatic t_zero();
    int_i = 37; frac_i = 0; dith_i = 0; en = 1'b1;
    do_init(0, 0, 0);
    repeat (4) cyc();
    for (int k = 0; k < 40; k++) begin
      cyc();
      check(out_o == 37, "R4 zero fraction", int'(out_o), 37);
    end
  endtask

  task automatic t_seed();
    int_i = 9; frac_i = 1; dith_i = 0; en = 1'b1;
    do_init(M - 1, 0, 0);
    repeat (4) cyc();
    check(out_o == 10, "R6 seeded first sample", int'(out_o), 10);
    do_init(12345, 777777, 1000000);
    int_i = 30; frac_i = 20'd98765;
    repeat (200) cyc();
  endtask

  task automatic t_ref();
    int_i = 12; frac_i = 20'd345678; dith_i = 0; en = 1'b1;
    do_init(0, 0, 0);
    repeat (400) cyc();
    int_i = 63; frac_i = 20'hFFFFF;
    do_init(3, M - 2, 500);
    repeat (300) cyc();
    int_i = 0; frac_i = 20'd1;
    do_init(M - 1, M - 1, M - 1);
    repeat (300) cyc();
  endtask

  task automatic t_dither();
    int_i = 5; frac_i = 5; dith_i = -8'sd100; en = 1'b1;
    do_init(0, 0, 0);
    repeat (4) cyc();
    for (int k = 0; k < 20; k++) begin
      cyc();
      check(out_o == 5, "R8 clamp at zero", int'(out_o), 5);
    end
    frac_i = FRAC_W'(M - 3); dith_i = 8'sd50;
    do_init(0, 0, 0);
    repeat (100) cyc();
    frac_i = 20'd500000;
    for (int k = 0; k < 300; k++) begin
      dith_i = DITH_W'((k * 37) % 256);
      cyc();
    end
    dith_i = 0;
  endtask

  task automatic t_hold();
    logic signed [OUT_W-1:0] held;
    int_i = 20; frac_i = 20'd777777; dith_i = 0; en = 1'b1;
    do_init(0, 0, 0);
    repeat (30) cyc();
    held = out_o;
    en = 1'b0;
    frac_i = 20'd3; int_i = 50;
    for (int k = 0; k < 5; k++) begin
      cyc();
      check(out_o == held, "R7 output held", int'(out_o), int'(held));
      check(valid_o == 1'b1, "R7 valid held", int'(valid_o), 1);
    end
    frac_i = 20'd777777; int_i = 20; en = 1'b1;
    repeat (60) cyc();
  endtask

  task automatic t_int();
    int_i = 20; frac_i = 0; dith_i = 0; en = 1'b1;
    do_init(0, 0, 0);
    repeat (10) cyc();
    int_i = 40;
    for (int k = 1; k <= 4; k++) begin
      cyc();
      check(out_o == ((k == 4) ? 40 : 20), "R9 integer latency", int'(out_o),
            (k == 4) ? 40 : 20);
    end
  endtask

  task automatic t_mean();
    longint lhs, rhs, diff;
    int_i = 12; frac_i = 20'd345678; dith_i = 0; en = 1'b1;
    do_init(0, 0, 0);
    sum_acc = 0; n_sum = 0; sum_on = 1;
    while (n_sum < 65536) cyc();
    sum_on = 0;
    lhs = sum_acc * 16;
    rhs = longint'(65536) * 12 * 16 + 345678;
    diff = (lhs > rhs) ? lhs - rhs : rhs - lhs;
    check(diff <= 64, "R1 long-term mean (x16)", int'(lhs), int'(rhs));
  endtask

  initial begin
    t_reset();
    t_latency();
    t_zero();
    t_seed();
    t_ref();
    t_dither();
    t_hold();
    t_int();
    t_mean();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 190000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 190000);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule